// File: doc/BRIEF.md
# Four-Master Gray-Order Round-Robin Bus Arbiter

This block shares one system bus among four bus masters. Each master drives its own request line and receives its own grant line. An eight-state machine moves a two-bit position pointer around the reflected-binary cycle 0 → 1 → 3 → 2 → 0. At each position the machine looks at that master's request. If the request is high, the master is granted. If not, the pointer moves on by one position per clock.

Once a master holds the bus, it keeps it for as long as its request stays high. When the request falls, the grant is withdrawn and the pointer moves to the next position in the cycle. Grants come straight from the state register, so at most one grant is ever active. Every hand-off passes through at least one cycle with no grant. Which master is served first depends on where the pointer happens to rest when the requests arrive.

The states are LOOK_M0, LOOK_M1, LOOK_M3 and LOOK_M2, which examine a position and assert no grant, and OWN_M0, OWN_M1, OWN_M3 and OWN_M2, which assert one grant. The transitions are:

- **look-hit**: from LOOK_Mp to OWN_Mp when req[p] is high.
- **look-miss**: from LOOK_Mp to the LOOK state of the next position when req[p] is low.
- **hold**: OWN_Mp stays in OWN_Mp while req[p] is high.
- **release**: from OWN_Mp to the LOOK state of the next position when req[p] is low.
- **reset**: any state goes to LOOK_M0.

Top module: `rr_gray_arbiter`

## Requirements
- R1: A synchronous active-high reset puts the machine in LOOK_M0 with all grants low. Master 0 is the first position examined after reset is released.
- R2: In LOOK_Mp with req[p] high, gnt[p] is high after the next rising clock edge.
- R3: In LOOK_Mp with req[p] low, the machine moves to the next position's LOOK state at the next edge and asserts no grant.
- R4: The positions are visited in the order 0, 1, 3, 2 and then back to 0.
- R5: While gnt[p] and req[p] are both high, gnt[p] is still high after the next edge, whatever the other requests do.
- R6: When a granted master's request is low, its grant is low after the next edge and the pointer moves to the following position's LOOK state.
- R7: At most one bit of gnt is high in any cycle.
- R8: Between two grants to different masters, or two separate grants to the same master, there is at least one cycle with no grant.
- R9: gnt[i] is high only if req[i] was high at the previous clock edge.
- R10: If all four masters request from the cycle reset is released, and each drops its request after a fixed number of granted cycles, the grants are issued in the order 0, 1, 3, 2.
- R11: If requests are held low for two clocks after reset and then all four masters request, master 3 is served first, followed by 2, 0 and 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 4 | Bus request, one bit per master, bit i for master i |
| gnt | output | 4 | Bus grant, one bit per master, bit i for master i; one-hot or zero |

## Verification
A pointer that skips a position, or that steps in binary rather than reflected-binary order, shows up at the grant pins within four clocks. The hand-off order and the start-position scenarios catch it at the first grant that goes to an unexpected master. A grant bit stuck in the hold state is seen on the first cycle after a request falls. A missing idle cycle between owners is seen the moment one grant replaces another directly. Because the bench model predicts gnt on every clock under both directed and random request patterns, any divergence in the state register is reported in the cycle it first reaches the outputs.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int NUM_MASTERS = 4;
    localparam int PTR_W       = $clog2(NUM_MASTERS);

    // Bit 2 marks an owning state, bits 1:0 hold the Gray-coded position.
    typedef enum logic [PTR_W:0] {
        ST_LOOK_M0 = 3'b000,
        ST_LOOK_M1 = 3'b001,
        ST_LOOK_M3 = 3'b011,
        ST_LOOK_M2 = 3'b010,
        ST_OWN_M0  = 3'b100,
        ST_OWN_M1  = 3'b101,
        ST_OWN_M3  = 3'b111,
        ST_OWN_M2  = 3'b110
    } arb_state_e;

endpackage

// File: rtl/arb_req_sel.sv
module arb_req_sel #(
    parameter int N     = 4,
    parameter int PTR_W = 2
) (
    input  logic [N-1:0]     req,
    input  logic [PTR_W-1:0] ptr,
    output logic             hit
);

    // Pick the request bit of the master under the pointer.
    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (ptr == PTR_W'(i)) begin
                hit = req[i];
            end
        end
    end

endmodule

// File: rtl/arb_grant_dec.sv
module arb_grant_dec #(
    parameter int N     = 4,
    parameter int PTR_W = 2
) (
    input  logic             own,
    input  logic [PTR_W-1:0] ptr,
    output logic [N-1:0]     gnt
);

    // One grant line per master, high only in an owning state.
    for (genvar i = 0; i < N; i++) begin : g_line
        assign gnt[i] = own && (ptr == PTR_W'(i));
    end

endmodule

// File: rtl/rr_gray_arbiter.sv
module rr_gray_arbiter
    import arb_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NUM_MASTERS-1:0] req,
    output logic [NUM_MASTERS-1:0] gnt
);

    arb_state_e       state_q;
    arb_state_e       state_d;
    logic             hit;
    logic             own_flag;
    logic [PTR_W-1:0] cur_ptr;

    arb_req_sel #(
        .N     (NUM_MASTERS),
        .PTR_W (PTR_W)
    ) u_sel (
        .req (req),
        .ptr (cur_ptr),
        .hit (hit)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_LOOK_M0;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: look-hit, look-miss, hold, release.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LOOK_M0: state_d = hit ? ST_OWN_M0 : ST_LOOK_M1;
            ST_LOOK_M1: state_d = hit ? ST_OWN_M1 : ST_LOOK_M3;
            ST_LOOK_M3: state_d = hit ? ST_OWN_M3 : ST_LOOK_M2;
            ST_LOOK_M2: state_d = hit ? ST_OWN_M2 : ST_LOOK_M0;
            ST_OWN_M0:  state_d = hit ? ST_OWN_M0 : ST_LOOK_M1;
            ST_OWN_M1:  state_d = hit ? ST_OWN_M1 : ST_LOOK_M3;
            ST_OWN_M3:  state_d = hit ? ST_OWN_M3 : ST_LOOK_M2;
            ST_OWN_M2:  state_d = hit ? ST_OWN_M2 : ST_LOOK_M0;
            default:    state_d = ST_LOOK_M0;
        endcase
    end

    // Outputs of the state: owning flag and position under the pointer.
    always_comb begin
        own_flag = 1'b0;
        cur_ptr  = '0;
        unique case (state_q)
            ST_LOOK_M0: begin own_flag = 1'b0; cur_ptr = 2'd0; end
            ST_LOOK_M1: begin own_flag = 1'b0; cur_ptr = 2'd1; end
            ST_LOOK_M3: begin own_flag = 1'b0; cur_ptr = 2'd3; end
            ST_LOOK_M2: begin own_flag = 1'b0; cur_ptr = 2'd2; end
            ST_OWN_M0:  begin own_flag = 1'b1; cur_ptr = 2'd0; end
            ST_OWN_M1:  begin own_flag = 1'b1; cur_ptr = 2'd1; end
            ST_OWN_M3:  begin own_flag = 1'b1; cur_ptr = 2'd3; end
            ST_OWN_M2:  begin own_flag = 1'b1; cur_ptr = 2'd2; end
            default:    begin own_flag = 1'b0; cur_ptr = 2'd0; end
        endcase
    end

    arb_grant_dec #(
        .N     (NUM_MASTERS),
        .PTR_W (PTR_W)
    ) u_dec (
        .own (own_flag),
        .ptr (cur_ptr),
        .gnt (gnt)
    );

endmodule

// File: rtl/rr_gray_arbiter_chk.sv
module rr_gray_arbiter_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] req,
    input logic [N-1:0] gnt
);

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        $past(rst) |-> gnt == '0);

    // R7
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    // R6
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (gnt != '0 && (gnt & req) == '0) |=> gnt == '0);

    // R8
    handoff_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(gnt) != '0 && gnt != $past(gnt)) |-> gnt == '0);

    for (genvar i = 0; i < N; i++) begin : g_bit
        // R5
        hold_chk: assert property (@(posedge clk) disable iff (rst)
            (gnt[i] && req[i]) |=> gnt[i]);

        // R9
        grant_had_req_chk: assert property (@(posedge clk) disable iff (rst)
            gnt[i] |-> $past(req[i]));
    end

endmodule

bind rr_gray_arbiter rr_gray_arbiter_chk #(
    .N (arb_pkg::NUM_MASTERS)
) u_chk (
    .clk (clk),
    .rst (rst),
    .req (req),
    .gnt (gnt)
);

// File: tb/rr_gray_arbiter_test.sv
module rr_gray_arbiter_test;

    localparam int CLK_PERIOD = 10;

    logic       clk;
    logic       rst;
    logic [3:0] req;
    logic [3:0] gnt;

    int checks;
    int failures;

    // Behavioural reference: index into the visiting order and an owning flag.
    int   seq_order [4] = '{0, 1, 3, 2};
    int   m_idx;
    bit   m_own;
    string cur_tag;

    // Bench-side masters and grant log.
    bit   auto_en;
    int   hold_len;
    int   held [4];
    int   glog [$];
    logic [3:0] prev_g;

    rr_gray_arbiter uut (
        .clk (clk),
        .rst (rst),
        .req (req),
        .gnt (gnt)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_idx <= 0;
            m_own <= 1'b0;
        end else if (m_own) begin
            if (!req[seq_order[m_idx]]) begin
                m_own <= 1'b0;
                m_idx <= (m_idx + 1) % 4;
            end
        end else if (req[seq_order[m_idx]]) begin
            m_own <= 1'b1;
        end else begin
            m_idx <= (m_idx + 1) % 4;
        end
    end

    function automatic logic [3:0] model_gnt();
        return m_own ? (4'b0001 << seq_order[m_idx]) : 4'b0000;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // One clock: sample at the falling edge, compare, then let masters react.
    task automatic tick();
        @(negedge clk);
        check(gnt === model_gnt(), cur_tag, gnt, model_gnt());
        check($countones(gnt) <= 1, "R7 one-hot", gnt, 4'b0000);
        if (gnt != 4'b0000 && gnt != prev_g) begin
            for (int i = 0; i < 4; i++) begin
                if (gnt[i]) glog.push_back(i);
            end
        end
        prev_g = gnt;
        if (auto_en) begin
            for (int i = 0; i < 4; i++) begin
                if (gnt[i]) begin
                    held[i]++;
                    if (held[i] >= hold_len) begin
                        req[i] = 1'b0;
                        held[i] = 0;
                    end
                end
            end
        end
    endtask

    task automatic do_reset();
        rst     = 1'b1;
        req     = 4'b0000;
        auto_en = 1'b0;
        repeat (3) @(negedge clk);
        check(gnt === 4'b0000, "R1 reset clears grants", gnt, 4'b0000);
        glog.delete();
        prev_g = 4'b0000;
        for (int i = 0; i < 4; i++) held[i] = 0;
        rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        checks   = 0;
        failures = 0;
        hold_len = 2;
        prev_g   = 4'b0000;

        // R1, R3: idle pointer pass-over from reset.
        do_reset();
        cur_tag = "R3 idle pass";
        repeat (6) tick();

        // R10, R4: all request from reset release.
        do_reset();
        req = 4'b1111;
        auto_en = 1'b1;
        cur_tag = "R10 all request";
        repeat (30) tick();
        check_int("R10 grant count", glog.size(), 4);
        if (glog.size() == 4) begin
            check_int("R4 order 1st", glog[0], 0);
            check_int("R4 order 2nd", glog[1], 1);
            check_int("R4 order 3rd", glog[2], 3);
            check_int("R4 order 4th", glog[3], 2);
        end

        // R11: two idle clocks, then all request.
        do_reset();
        cur_tag = "R11 start position";
        tick();
        tick();
        req = 4'b1111;
        auto_en = 1'b1;
        repeat (30) tick();
        check_int("R11 grant count", glog.size(), 4);
        if (glog.size() == 4) begin
            check_int("R11 first served", glog[0], 3);
            check_int("R11 second served", glog[1], 2);
        end

        // R2, R5, R6, R8: hold with competitors, release, hand-off gap.
        do_reset();
        req = 4'b1111;
        cur_tag = "R5 hold";
        tick();
        check(gnt === 4'b0001, "R2 grant one edge after look", gnt, 4'b0001);
        for (int k = 0; k < 8; k++) begin
            tick();
            check(gnt === 4'b0001, "R5 grant held", gnt, 4'b0001);
        end
        req = 4'b1110;
        cur_tag = "R6 release";
        tick();
        check(gnt === 4'b0000, "R6 grant dropped", gnt, 4'b0000);
        tick();
        check(gnt === 4'b0010, "R8 next owner after gap", gnt, 4'b0010);

        // R3, R4: single requester at position 2, then position 3.
        do_reset();
        req = 4'b0100;
        cur_tag = "R3 skip to 2";
        for (int k = 0; k < 3; k++) begin
            tick();
            check(gnt === 4'b0000, "R3 no grant while skipping", gnt, 4'b0000);
        end
        tick();
        check(gnt === 4'b0100, "R4 master 2 reached on 4th edge", gnt, 4'b0100);

        do_reset();
        req = 4'b1000;
        cur_tag = "R3 skip to 3";
        tick();
        tick();
        check(gnt === 4'b0000, "R3 no grant before 3", gnt, 4'b0000);
        tick();
        check(gnt === 4'b1000, "R4 master 3 reached on 3rd edge", gnt, 4'b1000);

        // R9, R7, R5, R6: random traffic against the model.
        do_reset();
        cur_tag = "R9 random traffic";
        for (int k = 0; k < 400; k++) begin
            req = 4'($urandom_range(0, 15));
            tick();
        end

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule